// File: doc/BRIEF.md
# Strobe-Captured Word Serializer

This block takes a parallel word on each rising edge of a strobe and sends it as a framed serial stream. Each frame is 26 bit times long. One bit goes out for every pulse on a bit-time enable. That enable is made outside the block from a reference clock multiplied by 26. Each frame carries a 24-slot payload. The slots hold the 20-bit data port, then two dedicated side bits, then two pad slots that are always zero.

The reference may run faster than the strobe and need not be phase-aligned to it. Any bit time that has no frame to carry sends a zero. A strobe that arrives while a frame is still going out is parked in a one-deep holding register. That word follows the current frame with no gap. A further strobe that finds the holding register full is dropped, and a sticky overrun flag is raised. Until the reference-lock indication is high, nothing is captured and nothing is sent.

Top module: `sws_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ser_out`, `bit_valid` and `overrun` are all 0.
- R2: While `lock` is high, a word is captured only in a cycle where `strobe` is 1 and was 0 in the previous cycle. A strobe held high for many cycles captures exactly one word.
- R3: A frame is 26 bits, sent in this order: a start bit of 1, then `par_data[0]` through `par_data[19]`, then `ded_data[0]` and `ded_data[1]`, then two 0 pad bits, then a stop bit of 0.
- R4: Each cycle with `bit_en` = 1 and `lock` = 1 moves the stream by one bit. `ser_out` changes and `bit_valid` is 1 in the next cycle. In every other cycle `bit_valid` is 0 and, while locked, `ser_out` holds its value.
- R5: A bit time with no frame to send carries `ser_out` = 0.
- R6: A word waiting in the holding register starts its start bit in the bit time right after the previous frame's stop bit.
- R7: A strobe that arrives during a frame, with the holding register empty, is stored and sent later without setting `overrun`. A strobe in the same cycle that the held word moves into the shifter is also accepted.
- R8: A strobe that finds the holding register full, and not being emptied in that cycle, is dropped. It sets `overrun`, which stays 1 until reset.
- R9: While `lock` is 0, strobes are dropped, the frame in flight and the held word are discarded, and `ser_out` and `bit_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Reference-locked indication; high enables capture and sending |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| strobe | input | 1 | Capture strobe; its rising edge samples the word |
| par_data | input | 20 | Parallel data word, bit 0 sent first |
| ded_data | input | 2 | Dedicated side bits, sent after the data word |
| ser_out | output | 1 | Serial data stream |
| bit_valid | output | 1 | High in the cycle that a new serial bit is presented |
| overrun | output | 1 | Sticky flag: a strobe was lost to a full holding register |

## Verification
The bench builds the block with its default widths: 20 data bits, 2 side bits and 2 pad slots, which give a 26-bit frame. It pulses `bit_en` every third clock, so one frame takes 78 clocks. Strobe spacing can then be placed just above or well below the frame length. This reaches idle zero gaps, back-to-back frames out of the holding register, and overrun from a burst of three strobes. A separate deframer decodes the stream on its own. It checks the position of every payload, pad and stop bit against the words the model expects.

// File: rtl/sws_pkg.sv
`timescale 1ns/1ps
package sws_pkg;
    localparam int unsigned START_BITS = 1;
    localparam int unsigned STOP_BITS  = 1;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_SEND = 1'b1
    } fr_mode_e;
endpackage

// File: rtl/sws_strobe_edge.sv
`timescale 1ns/1ps
module sws_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic lock,
    output logic rise
);
    typedef struct packed {
        logic strobe;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = strobe;
        rise        = strobe & ~st_q.strobe & lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sws_hold.sv
`timescale 1ns/1ps
module sws_hold #(
    parameter int unsigned WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word_out,
    output logic              overrun
);
    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        logic              ovr;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!lock) begin
            st_d.full = 1'b0;
        end else begin
            if (take) st_d.full = 1'b0;
            if (capture) begin
                if (!st_q.full || take) begin
                    st_d.full = 1'b1;
                    st_d.word = word_in;
                end else begin
                    st_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full     = st_q.full;
    assign word_out = st_q.word;
    assign overrun  = st_q.ovr;
endmodule

// File: rtl/sws_shifter.sv
`timescale 1ns/1ps
module sws_shifter
    import sws_pkg::*;
#(
    parameter int unsigned WORD_W = 22,
    parameter int unsigned PAD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              bit_en,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    output logic              take,
    output logic              ser_out,
    output logic              bit_valid
);
    localparam int unsigned FRAME_W = START_BITS + WORD_W + PAD_W + STOP_BITS;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        fr_mode_e           mode;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               ser;
        logic               vld;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [FRAME_W-1:0] frame;

    // frame vector, bit 0 leaves first
    generate
        if (PAD_W > 0) begin : g_pad
            assign frame = {1'b0, {PAD_W{1'b0}}, hold_word, 1'b1};
        end else begin : g_nopad
            assign frame = {1'b0, hold_word, 1'b1};
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        st_d.vld = bit_en & lock;
        if (!lock) begin
            st_d.mode = FR_IDLE;
            st_d.cnt  = '0;
            st_d.sh   = '0;
            st_d.ser  = 1'b0;
        end else if (bit_en) begin
            if (st_q.mode == FR_SEND && st_q.cnt != LAST_IDX) begin
                st_d.ser = st_q.sh[0];
                st_d.sh  = st_q.sh >> 1;
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (hold_full) begin
                take      = 1'b1;
                st_d.mode = FR_SEND;
                st_d.cnt  = '0;
                st_d.ser  = frame[0];
                st_d.sh   = frame >> 1;
            end else begin
                st_d.mode = FR_IDLE;
                st_d.cnt  = '0;
                st_d.ser  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: FR_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign ser_out   = st_q.ser;
    assign bit_valid = st_q.vld;
endmodule

// File: rtl/sws_serializer.sv
`timescale 1ns/1ps
module sws_serializer #(
    parameter int unsigned PAR_W = 20,
    parameter int unsigned DED_W = 2,
    parameter int unsigned PAD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             bit_en,
    input  logic             strobe,
    input  logic [PAR_W-1:0] par_data,
    input  logic [DED_W-1:0] ded_data,
    output logic             ser_out,
    output logic             bit_valid,
    output logic             overrun
);
    localparam int unsigned WORD_W = PAR_W + DED_W;

    logic              rise_w;
    logic              take_w;
    logic              hold_full_w;
    logic [WORD_W-1:0] hold_word_w;

    sws_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .lock   (lock),
        .rise   (rise_w)
    );

    sws_hold #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (lock),
        .capture  (rise_w),
        .word_in  ({ded_data, par_data}),
        .take     (take_w),
        .full     (hold_full_w),
        .word_out (hold_word_w),
        .overrun  (overrun)
    );

    sws_shifter #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .bit_en    (bit_en),
        .hold_full (hold_full_w),
        .hold_word (hold_word_w),
        .take      (take_w),
        .ser_out   (ser_out),
        .bit_valid (bit_valid)
    );
endmodule

// File: rtl/sws_serializer_chk.sv
`timescale 1ns/1ps
module sws_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic lock,
    input logic bit_en,
    input logic rise,
    input logic take,
    input logic hold_full,
    input logic ser_out,
    input logic bit_valid,
    input logic overrun
);
    // R4: a presented bit always traces back to an enabled, locked bit time
    a_r4_valid_from_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> ($past(bit_en) && $past(lock)));

    // R4: serial line only moves with a new bit (or when lock clears it)
    a_r4_ser_moves_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out != $past(ser_out)) |-> (bit_valid || !$past(lock)));

    // R6: a frame leaving the holding register opens with a start bit
    a_r6_start_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ser_out && bit_valid));

    // R7: the shifter only draws from a full holding register
    a_r7_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_full);

    // R8: a capture into a full, undrained holding register raises overrun
    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && hold_full && !take) |=> overrun);

    // R8: overrun is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: nothing leaves the block while unlocked
    a_r9_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lock) |-> (!ser_out && !bit_valid));
endmodule

bind sws_serializer sws_serializer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (lock),
    .bit_en    (bit_en),
    .rise      (rise_w),
    .take      (take_w),
    .hold_full (hold_full_w),
    .ser_out   (ser_out),
    .bit_valid (bit_valid),
    .overrun   (overrun)
);

// File: tb/test_sws_serializer.sv
`timescale 1ns/1ps
module test_sws_serializer;
    localparam int PW = 20;
    localparam int DW = 2;
    localparam int PADW = 2;
    localparam int WW = PW + DW;
    localparam int FW = 1 + WW + PADW + 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, lock, bit_en, strobe;
    logic [PW-1:0] par;
    logic [DW-1:0] ded;
    logic ser_out, bit_valid, overrun;

    sws_serializer i_sws_serializer (
        .clk(clk), .rst_n(rst_n), .lock(lock), .bit_en(bit_en), .strobe(strobe),
        .par_data(par), .ded_data(ded),
        .ser_out(ser_out), .bit_valid(bit_valid), .overrun(overrun)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_sprev, m_ser, m_vld, m_ovr, m_lk, m_rise;
    int m_pos = -1;
    logic [WW-1:0] m_hold[$];
    logic [WW-1:0] m_sent[$];
    logic [WW-1:0] m_cur;

    function automatic bit fbit(input logic [WW-1:0] w, input int k);
        if (k == 0) return 1'b1;
        if (k <= WW) return w[k-1];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sprev = 0; m_ser = 0; m_vld = 0; m_ovr = 0; m_lk = 0;
            m_pos = -1; m_hold.delete(); m_sent.delete();
        end else begin
            m_rise  = strobe && !m_sprev && lock;
            m_sprev = strobe;
            m_lk    = lock;
            if (!lock) begin
                m_hold.delete(); m_pos = -1; m_ser = 0; m_vld = 0;
            end else begin
                m_vld = bit_en;
                if (bit_en) begin
                    if (m_pos >= 0 && m_pos < FW-1) begin
                        m_pos++;
                        m_ser = fbit(m_cur, m_pos);
                        if (m_pos == FW-1) m_sent.push_back(m_cur);
                    end else if (m_hold.size() > 0) begin
                        m_cur = m_hold.pop_front();
                        m_pos = 0;
                        m_ser = 1;
                    end else begin
                        m_pos = -1;
                        m_ser = 0;
                    end
                end
                if (m_rise) begin
                    if (m_hold.size() == 0) m_hold.push_back({ded, par});
                    else m_ovr = 1;
                end
            end
        end
    end

    // ---------------- per-cycle compare ----------------
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            check(ser_out === m_ser, "R3", "ser_out vs model", 64'(ser_out), 64'(m_ser));
            check(bit_valid === m_vld, "R4", "bit_valid vs model", 64'(bit_valid), 64'(m_vld));
            check(overrun === m_ovr, "R8", "overrun vs model", 64'(overrun), 64'(m_ovr));
        end
    end

    // ---------------- independent deframer ----------------
    int dk = -1;
    int rx_count = 0;
    int idle_zero = 0;
    int gap_cnt = 0;
    int last_gap = -1;
    logic [FW-1:0] fb;

    always @(negedge clk) begin
        if (rst_n !== 1'b1 || !m_lk) begin
            dk = -1;
        end else if (bit_valid) begin
            if (dk < 0) begin
                if (ser_out) begin
                    dk = 0; fb = '0; fb[0] = 1'b1;
                    last_gap = gap_cnt;
                end else begin
                    idle_zero++;
                    gap_cnt++;
                end
            end else begin
                dk++;
                fb[dk] = ser_out;
                if (dk == FW-1) begin
                    // R3: pad slots and stop bit are zero
                    check(fb[FW-1:WW+1] == '0, "R3", "pad+stop bits",
                          64'(fb[FW-1:WW+1]), 64'd0);
                    if (m_sent.size() > 0) begin
                        logic [WW-1:0] e;
                        e = m_sent.pop_front();
                        check(fb[WW:1] == e, "R3", "decoded word", 64'(fb[WW:1]), 64'(e));
                    end else begin
                        check(1'b0, "R6", "unexpected frame", 64'(fb[WW:1]), 64'd0);
                    end
                    rx_count++;
                    gap_cnt = 0;
                    dk = -1;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    int ecnt = 0;
    initial begin
        bit_en = 1'b0;
        forever begin
            @(negedge clk);
            bit_en = (ecnt == 2);
            ecnt = (ecnt == 2) ? 0 : ecnt + 1;
        end
    end

    task automatic strobe_word(input logic [WW-1:0] w);
        @(negedge clk);
        par = w[PW-1:0];
        ded = w[WW-1:PW];
        strobe = 1'b1;
        repeat (2) @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int base;
        int iz;
        rst_n = 1'b0; lock = 1'b0; strobe = 1'b0; par = '0; ded = '0;
        idle(5);
        // R1: reset state
        check(ser_out === 1'b0, "R1", "ser_out in reset", 64'(ser_out), 64'd0);
        check(bit_valid === 1'b0, "R1", "bit_valid in reset", 64'(bit_valid), 64'd0);
        check(overrun === 1'b0, "R1", "overrun in reset", 64'(overrun), 64'd0);
        rst_n = 1'b1;
        idle(1);
        check(ser_out === 1'b0 && bit_valid === 1'b0, "R1", "outputs after reset",
              64'({ser_out, bit_valid}), 64'd0);

        // R9: strobes before lock are dropped
        strobe_word(22'h0A5A5A);
        idle(10);
        strobe_word(22'h3FFFFF);
        idle(100);
        check(rx_count == 0, "R9", "frames before lock", 64'(rx_count), 64'd0);

        // R2: long strobe level captures a single word
        lock = 1'b1;
        idle(10);
        @(negedge clk);
        par = 20'h8_1234; ded = 2'b10; strobe = 1'b1;
        idle(150);
        strobe = 1'b0;
        idle(60);
        check(rx_count == 1, "R2", "one frame per held strobe", 64'(rx_count), 64'd1);

        // R5: slow strobes leave zero-filled gaps
        base = rx_count;
        iz = idle_zero;
        for (int i = 0; i < 4; i++) begin
            strobe_word(22'(32'h2C_3E91 * (i + 3)) ^ 22'h15_5AA5);
            idle(110);
        end
        check(rx_count - base == 4, "R5", "frames with gaps", 64'(rx_count - base), 64'd4);
        check(idle_zero - iz > 30, "R5", "idle zero bits seen", 64'(idle_zero - iz), 64'd31);

        // R6 / R7: second strobe during a frame is held and sent back to back
        base = rx_count;
        strobe_word(22'h1F_0F0F);
        idle(20);
        strobe_word(22'h20_F0F1);
        idle(200);
        check(rx_count - base == 2, "R7", "held word delivered", 64'(rx_count - base), 64'd2);
        check(last_gap == 0, "R6", "gap before held frame", 64'(last_gap), 64'd0);
        check(overrun === 1'b0, "R7", "no overrun for one held word", 64'(overrun), 64'd0);

        // R8: third strobe with full holding register is lost
        base = rx_count;
        strobe_word(22'h11_1111);
        idle(10);
        strobe_word(22'h22_2222);
        idle(10);
        strobe_word(22'h33_3333);
        idle(250);
        check(overrun === 1'b1, "R8", "overrun set", 64'(overrun), 64'd1);
        check(rx_count - base == 2, "R8", "dropped word not sent", 64'(rx_count - base), 64'd2);

        // R9: lock loss mid-frame discards it
        base = rx_count;
        strobe_word(22'h2A_BCDE);
        idle(30);
        lock = 1'b0;
        idle(20);
        lock = 1'b1;
        idle(150);
        check(rx_count - base == 0, "R9", "aborted frame not resumed", 64'(rx_count - base), 64'd0);
        strobe_word(22'h05_6789);
        idle(120);
        check(rx_count - base == 1, "R9", "sending resumes after relock", 64'(rx_count - base), 64'd1);
        check(overrun === 1'b1, "R8", "overrun still set", 64'(overrun), 64'd1);
        check(m_sent.size() == 0, "R3", "all model frames received", 64'(m_sent.size()), 64'd0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule